// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block holds a small set of recently used page translations and answers address lookups against all of them at once. A lookup presents a 32-bit virtual address and a read/write flag. The upper 20 bits name the virtual page and the low 12 bits are the offset within a 4 KB page. One cycle later the block reports one of three outcomes:

- a translation: the stored frame number joined to the untouched offset;
- a miss trap, when no valid entry holds the page;
- a protection fault, when an entry holds the page but does not permit the requested kind of access.

The block never walks page tables itself. When a miss trap is raised, the trap handler writes the translation through a dedicated install port and then re-issues the access, which then hits.

An install goes to the slot held by a round-robin pointer. If the page is already present, the install overwrites that existing slot instead, so a page can never sit in two entries. A one-cycle invalidate empties the whole buffer. When several requests arrive together, invalidate beats install and install beats lookup.

Top module: `sw_tlb`

## Requirements
- R1: A lookup whose page matches a valid entry that allows the access returns, one cycle later, `res_hit`=1 and `res_paddr` = {stored frame number, lookup address bits [11:0]}.
- R2: A lookup whose page matches no valid entry returns, one cycle later, `res_miss`=1 and `res_paddr`=0.
- R3: A lookup that matches an entry whose permission bit for that kind of access is 0 (`lk_write`=1 checks the write bit, `lk_write`=0 checks the read bit) returns `res_prot_fault`=1, `res_miss`=0 and `res_paddr`=0.
- R4: `res_valid` is 1 exactly one cycle after each accepted lookup, with exactly one of `res_hit`, `res_miss` and `res_prot_fault` set; in every other cycle all result outputs are 0.
- R5: An install makes its translation visible to a lookup issued in the very next cycle.
- R6: Installing a page number that is already present overwrites that entry's frame number and permissions, and leaves no second copy.
- R7: Installs of pages not yet present fill slots in round-robin order, so after 16 such installs a 17th evicts the first of those 16 and keeps the other 15.
- R8: `inv_all` clears every entry in one cycle; an install in the same cycle is discarded.
- R9: An install in the same cycle as a lookup takes priority: the install is performed and the lookup is dropped (`res_valid`=0 in the next cycle).
- R10: Synchronous active-low reset clears all result outputs and all entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_vaddr | input | 32 | Virtual address to translate |
| ins_en | input | 1 | Install a translation this cycle |
| ins_vpn | input | 20 | Virtual page number to install |
| ins_pfn | input | 20 | Physical frame number to install |
| ins_rd_ok | input | 1 | Installed entry permits reads |
| ins_wr_ok | input | 1 | Installed entry permits writes |
| inv_all | input | 1 | Invalidate all entries |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | Miss trap |
| res_prot_fault | output | 1 | Access permission fault |
| res_paddr | output | 32 | Physical address on hit, else 0 |

## Verification
Two activities can land in one cycle and must be arbitrated: a lookup together with an install, and an install together with an invalidate. The bench drives an install of a new page in the same cycle as a lookup of that page. It judges that no result appears in the next cycle, and that a re-issued lookup then hits with the new frame. It also pairs an install with an invalidate and expects the page to miss afterwards. The refill sequence of miss, install and retry-hit is checked, as is overwrite of a page that is already present.

// File: rtl/sw_tlb_pkg.sv
// Package: shared types for the software-refilled translation buffer.
// Assumes: two permission bits per entry (read, write).
package sw_tlb_pkg;

    // Access permissions held per entry
    typedef struct packed {
        logic rd;
        logic wr;
    } tlb_perm_t;

    // Outcome of one lookup before it is registered
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_MISS  = 2'd2,
        OUT_FAULT = 2'd3
    } tlb_outcome_e;

endpackage

// File: rtl/tlb_entry_array.sv
// Module: entry storage and parallel compare for the translation buffer.
// Holds ENTRIES slots of {valid, page, frame, perms}. It compares both the
// lookup page and the install page against every slot, and muxes out the
// frame and permissions of the lookup match.
// Assumes: at most one slot matches a page (the install logic ensures this).
module tlb_entry_array
    import sw_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_all,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  tlb_perm_t          wr_perm,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic [ENTRIES-1:0] look_match,
    output logic [ENTRIES-1:0] ins_match,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [PFN_W-1:0]   hit_pfn,
    output tlb_perm_t          hit_perm
);

    logic [VPN_W-1:0] vpn_q  [ENTRIES];
    logic [PFN_W-1:0] pfn_q  [ENTRIES];
    tlb_perm_t        perm_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Slot update: reset or clear empties all, write fills one slot
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                vpn_q[i]   <= '0;
                pfn_q[i]   <= '0;
                perm_q[i]  <= '0;
            end else if (clear_all) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
                vpn_q[i]   <= wr_vpn;
                pfn_q[i]   <= wr_pfn;
                perm_q[i]  <= wr_perm;
            end
        end
    end

    // Per-slot comparators for the lookup page and the install page
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign look_match[g] = valid_q[g] && (vpn_q[g] == look_vpn);
        assign ins_match[g]  = valid_q[g] && (vpn_q[g] == wr_vpn);
    end

    assign valid_vec = valid_q;

    // One-hot OR mux of the matching slot's frame and permissions
    always_comb begin
        hit_pfn  = '0;
        hit_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) begin
                hit_pfn  = hit_pfn | pfn_q[i];
                hit_perm = hit_perm | perm_q[i];
            end
        end
    end

endmodule

// File: rtl/tlb_fill_ctrl.sv
// Module: install slot selection for the translation buffer.
// Sends an install to the slot already holding the page, if there is one.
// Otherwise it uses the round-robin pointer, which then advances.
// Assumes: ins_match is one-hot or zero; invalidate discards an install.
module tlb_fill_ctrl #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_en,
    input  logic               clear_all,
    input  logic [ENTRIES-1:0] ins_match,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] match_idx;
    logic             present;

    // Encode the one-hot match of the install page into a slot index
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ins_match[i]) match_idx = match_idx | IDX_W'(i);
        end
    end

    assign present = |ins_match;
    assign wr_en   = ins_en && !clear_all;
    assign wr_idx  = present ? match_idx : rr_ptr;

    // Round-robin pointer: steps only when a new slot is allocated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (wr_en && !present) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_result_reg.sv
// Module: outcome decision and output register for a lookup.
// Classifies a lookup as hit, miss or permission fault and registers it,
// giving the one-cycle lookup latency. The address is zero unless a hit.
// Assumes: hit_pfn and hit_perm are meaningful only when any_match is set.
module tlb_result_reg
    import sw_tlb_pkg::*;
#(
    parameter int PFN_W = 20,
    parameter int OFF_W = 12,
    localparam int PA_W = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             is_write,
    input  logic             any_match,
    input  tlb_perm_t        hit_perm,
    input  logic [PFN_W-1:0] hit_pfn,
    input  logic [OFF_W-1:0] offset,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_prot_fault,
    output logic [PA_W-1:0]  res_paddr
);

    tlb_outcome_e outcome;
    logic         allowed;

    // Decide the outcome of the current lookup
    always_comb begin
        allowed = is_write ? hit_perm.wr : hit_perm.rd;
        if (!req)            outcome = OUT_NONE;
        else if (!any_match) outcome = OUT_MISS;
        else if (!allowed)   outcome = OUT_FAULT;
        else                 outcome = OUT_HIT;
    end

    // Register the outcome and the translated address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            res_hit        <= 1'b0;
            res_miss       <= 1'b0;
            res_prot_fault <= 1'b0;
            res_paddr      <= '0;
        end else begin
            res_valid      <= (outcome != OUT_NONE);
            res_hit        <= (outcome == OUT_HIT);
            res_miss       <= (outcome == OUT_MISS);
            res_prot_fault <= (outcome == OUT_FAULT);
            res_paddr      <= (outcome == OUT_HIT) ? {hit_pfn, offset} : '0;
        end
    end

endmodule

// File: rtl/sw_tlb.sv
// Module: top of the software-refilled translation buffer.
// Splits the lookup address into page and offset, arbitrates
// invalidate > install > lookup, and connects storage, slot choice and
// the result register.
// Assumes: VA_W = VPN_W + OFF_W; software reissues a lookup dropped by an install.
module sw_tlb
    import sw_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic             ins_rd_ok,
    input  logic             ins_wr_ok,
    input  logic             inv_all,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_prot_fault,
    output logic [PA_W-1:0]  res_paddr
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0]   look_vpn;
    logic [OFF_W-1:0]   look_off;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] in_match;
    logic [ENTRIES-1:0] entry_valid;
    logic [PFN_W-1:0]   sel_pfn;
    tlb_perm_t          sel_perm;
    tlb_perm_t          new_perm;
    logic               slot_wr;
    logic [IDX_W-1:0]   slot_idx;
    logic               lookup_go;

    assign look_vpn  = lk_vaddr[VA_W-1:OFF_W];
    assign look_off  = lk_vaddr[OFF_W-1:0];
    assign new_perm  = '{rd: ins_rd_ok, wr: ins_wr_ok};
    // Lookup is accepted only when neither install nor invalidate is present
    assign lookup_go = lk_valid && !ins_en && !inv_all;

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (inv_all),
        .wr_en      (slot_wr),
        .wr_idx     (slot_idx),
        .wr_vpn     (ins_vpn),
        .wr_pfn     (ins_pfn),
        .wr_perm    (new_perm),
        .look_vpn   (look_vpn),
        .look_match (lk_match),
        .ins_match  (in_match),
        .valid_vec  (entry_valid),
        .hit_pfn    (sel_pfn),
        .hit_perm   (sel_perm)
    );

    tlb_fill_ctrl #(
        .ENTRIES (ENTRIES)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_en    (ins_en),
        .clear_all (inv_all),
        .ins_match (in_match),
        .wr_en     (slot_wr),
        .wr_idx    (slot_idx)
    );

    tlb_result_reg #(
        .PFN_W (PFN_W),
        .OFF_W (OFF_W)
    ) u_result (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (lookup_go),
        .is_write       (lk_write),
        .any_match      (|lk_match),
        .hit_perm       (sel_perm),
        .hit_pfn        (sel_pfn),
        .offset         (look_off),
        .res_valid      (res_valid),
        .res_hit        (res_hit),
        .res_miss       (res_miss),
        .res_prot_fault (res_prot_fault),
        .res_paddr      (res_paddr)
    );

endmodule

// File: rtl/tlb_checker.sv
// Module: assertion checker bound to sw_tlb.
// Watches ports and the per-slot match and valid vectors.
// Assumes: synchronous active-low reset on rst_n.
module tlb_checker #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PA_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               ins_en,
    input logic               inv_all,
    input logic               res_valid,
    input logic               res_hit,
    input logic               res_miss,
    input logic               res_prot_fault,
    input logic [PA_W-1:0]    res_paddr,
    input logic [ENTRIES-1:0] match_vec,
    input logic [ENTRIES-1:0] valid_vec
);

    // R4: an accepted lookup yields a result next cycle
    a_r4_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !ins_en && !inv_all) |=> res_valid);

    // R4: a valid result carries exactly one outcome
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_hit, res_miss, res_prot_fault}) == 1));

    // R4: no outcome flags or address without a result
    a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_miss && !res_prot_fault && res_paddr == '0));

    // R1: the offset bits pass through unchanged on a hit
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !ins_en && !inv_all) |=>
            (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R2: a miss produces no address
    a_r2_miss_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_paddr == '0));

    // R3: a fault produces no address
    a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        res_prot_fault |-> (res_paddr == '0));

    // R6: a page never sits in two slots
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R8: invalidate empties every slot in one cycle
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    // R9: an install drops a same-cycle lookup
    a_r9_install_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> !res_valid);

endmodule

bind sw_tlb tlb_checker #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .PA_W    (PA_W)
) u_tlb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_vaddr       (lk_vaddr),
    .ins_en         (ins_en),
    .inv_all        (inv_all),
    .res_valid      (res_valid),
    .res_hit        (res_hit),
    .res_miss       (res_miss),
    .res_prot_fault (res_prot_fault),
    .res_paddr      (res_paddr),
    .match_vec      (lk_match),
    .valid_vec      (entry_valid)
);

// File: tb/tb_sw_tlb.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed reset and corner-case tests.
module tb_sw_tlb;

    localparam logic [1:0] OP_INS = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;
    localparam logic [1:0] K_NONE = 2'd0, K_HIT = 2'd1, K_MISS = 2'd2, K_FLT = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;   // lookup address, or install page in [31:12]
        logic [19:0] pfn;
        logic        rd_ok;
        logic        wr_ok;
        logic [1:0]  kind;
        logic [31:0] pa;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,  32'h0000_1234, 20'h0,     1'b0, 1'b0, K_MISS, 32'h0,         4'd2},
        '{OP_INS, 32'h0000_1000, 20'hABCDE, 1'b1, 1'b0, K_NONE, 32'h0,         4'd5},
        '{OP_RD,  32'h0000_1234, 20'h0,     1'b0, 1'b0, K_HIT,  32'hABCD_E234, 4'd5},
        '{OP_WR,  32'h0000_1FFF, 20'h0,     1'b0, 1'b0, K_FLT,  32'h0,         4'd3},
        '{OP_INS, 32'h0000_1000, 20'h12345, 1'b1, 1'b1, K_NONE, 32'h0,         4'd6},
        '{OP_WR,  32'h0000_1FFF, 20'h0,     1'b0, 1'b0, K_HIT,  32'h1234_5FFF, 4'd6},
        '{OP_INS, 32'h0000_2000, 20'h00077, 1'b0, 1'b1, K_NONE, 32'h0,         4'd5},
        '{OP_RD,  32'h0000_2000, 20'h0,     1'b0, 1'b0, K_FLT,  32'h0,         4'd3},
        '{OP_WR,  32'h0000_2ABC, 20'h0,     1'b0, 1'b0, K_HIT,  32'h0007_7ABC, 4'd1},
        '{OP_RD,  32'hFFFF_F000, 20'h0,     1'b0, 1'b0, K_MISS, 32'h0,         4'd2},
        '{OP_INS, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, K_NONE, 32'h0,         4'd5},
        '{OP_RD,  32'hFFFF_FFFF, 20'h0,     1'b0, 1'b0, K_HIT,  32'hFFFF_FFFF, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        ins_en = 1'b0, ins_rd_ok = 1'b0, ins_wr_ok = 1'b0, inv_all = 1'b0;
    logic [19:0] ins_vpn = '0, ins_pfn = '0;
    logic        res_valid, res_hit, res_miss, res_prot_fault;
    logic [31:0] res_paddr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sw_tlb dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn),
        .ins_rd_ok(ins_rd_ok), .ins_wr_ok(ins_wr_ok), .inv_all(inv_all),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_prot_fault(res_prot_fault), .res_paddr(res_paddr)
    );

    // Compare all outputs against an expected outcome and address
    task automatic expect_out(input string rq, input logic v, input logic [1:0] k,
                              input logic [31:0] pa);
        logic [35:0] got, exp;
        got = {res_valid, res_hit, res_miss, res_prot_fault, res_paddr};
        exp = {v, k == K_HIT, k == K_MISS, k == K_FLT, pa};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got v/h/m/f=%b%b%b%b pa=%h, expected %b%b%b%b pa=%h",
                     rq, got[35], got[34], got[33], got[32], got[31:0],
                     exp[35], exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Drive one cycle of inputs, return after the edge at the next negedge
    task automatic cycle(input logic lv, input logic lw, input logic [31:0] va,
                         input logic ie, input logic [19:0] iv, input logic [19:0] ip,
                         input logic ir, input logic iw, input logic fl);
        lk_valid = lv; lk_write = lw; lk_vaddr = va;
        ins_en = ie; ins_vpn = iv; ins_pfn = ip; ins_rd_ok = ir; ins_wr_ok = iw;
        inv_all = fl;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; ins_en = 1'b0; inv_all = 1'b0;
    endtask

    task automatic install(input logic [19:0] v, input logic [19:0] p,
                           input logic r, input logic w);
        cycle(1'b0, 1'b0, '0, 1'b1, v, p, r, w, 1'b0);
    endtask

    task automatic lookup(input logic w, input logic [31:0] va);
        cycle(1'b1, w, va, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs are zero while in reset
        expect_out("R10 reset outputs", 1'b0, K_NONE, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk: R1 R2 R3 R5 R6
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == OP_INS)
                install(VECS[i].addr[31:12], VECS[i].pfn, VECS[i].rd_ok, VECS[i].wr_ok);
            else
                lookup(VECS[i].op == OP_WR, VECS[i].addr);
            expect_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                       VECS[i].op != OP_INS, VECS[i].kind, VECS[i].pa);
        end

        // R4: idle cycle gives no result
        cycle(1'b0, 1'b0, 32'h0000_1234, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        expect_out("R4 idle", 1'b0, K_NONE, 32'h0);

        // R9: install and lookup of the same page together; lookup dropped
        cycle(1'b1, 1'b0, 32'h0000_3456, 1'b1, 20'h00003, 20'h0BEEF, 1'b1, 1'b0, 1'b0);
        expect_out("R9 lookup dropped", 1'b0, K_NONE, 32'h0);
        lookup(1'b0, 32'h0000_3456);
        expect_out("R9 retry hits", 1'b1, K_HIT, 32'h0BEE_F456);

        // R8: invalidate clears everything
        cycle(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        lookup(1'b0, 32'h0000_3456);
        expect_out("R8 miss after invalidate", 1'b1, K_MISS, 32'h0);
        lookup(1'b1, 32'hFFFF_FFFF);
        expect_out("R8 second page gone", 1'b1, K_MISS, 32'h0);

        // R8: install in the same cycle as invalidate is discarded
        cycle(1'b0, 1'b0, '0, 1'b1, 20'h00044, 20'h00555, 1'b1, 1'b1, 1'b1);
        lookup(1'b0, 32'h0004_4000);
        expect_out("R8 install discarded", 1'b1, K_MISS, 32'h0);

        // R7: 17 new pages into an empty buffer; the first is evicted
        for (int i = 0; i < 17; i++) install(20'h00100 + 20'(i), 20'h20000 + 20'(i), 1'b1, 1'b1);
        lookup(1'b0, 32'h0010_0010);
        expect_out("R7 oldest evicted", 1'b1, K_MISS, 32'h0);
        for (int i = 1; i < 17; i++) begin
            lookup(1'b0, {20'h00100 + 20'(i), 12'h0AB});
            expect_out($sformatf("R7 page %0d kept", i), 1'b1, K_HIT,
                       {20'h20000 + 20'(i), 12'h0AB});
        end

        // R10: reset empties entries
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(1'b0, {20'h00105, 12'h0AB});
        expect_out("R10 entries cleared", 1'b1, K_MISS, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule